// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit buses, called A and B, in both directions. Each direction has a capture register, a capture strobe, a source select and an output enable. The path is divided into two 8-bit lanes (bits 7:0 and bits 15:8). Each lane has its own complete set of controls, and the two lanes run independently. A select value of 0 passes the opposite bus straight through in real time. A select value of 1 drives the value that was captured earlier. Capture does not depend on select or enable, so a lane can record traffic while it stays isolated.

Each bus side is modelled as separate input, output and output-enable ports, so no tristate nets are needed. The design works internally with an "effective" bus value per side. When that side is not driving, the effective value is the external input. When it is driving, the effective value is the value the block drives. Capture registers and the real-time path both use this effective value. A lane can enable both directions with both selects on real time. In that case each bus would feed back on itself, and this is modelled with a per-lane hold register, so the buses keep their last value.

Top module: `bus_xfer_reg`

## Requirements
- R1: A rising edge of `cap_ab[l]` is the strobe going from 0 to 1 between two consecutive `clk` edges. On that edge, the lane-l A→B register loads the effective A value. This happens whatever the lane's select and enable settings are.
- R2: A rising edge of `cap_ba[l]` makes the lane-l B→A register load the effective B value, under the same rule as R1.
- R3: `b_oe[l]` equals `oe_ab[l]`, which is active high. `a_oe[l]` equals the inverse of `oe_ba_n[l]`, which is active low. The data output of a side that is not driving reads 0.
- R4: With `sel_ab[l]`=0 and B driving (and the lane not in self-hold), the B outputs show the effective A value in the same cycle. With `sel_ba[l]`=0 and A driving, the A outputs show the effective B value in the same way.
- R5: With `sel_ab[l]`=1 and B driving, the B outputs show the A→B register. With `sel_ba[l]`=1 and A driving, the A outputs show the B→A register.
- R6: With `oe_ab[l]`=0 and `oe_ba_n[l]`=1, the lane is isolated. Neither side drives, and the effective values equal the external inputs. Captures still occur as R1 and R2 describe.
- R7: With both sides driving and both selects at 0, the lane is in self-hold. Both buses show a held value. That value is the effective A value of the last cycle before self-hold began, and it does not change, whatever the inputs do, until self-hold ends.
- R8: With both sides driving and both selects at 1, the B outputs show the A→B register and the A outputs show the B→A register in the same cycle.
- R9: A capture on a side that is driving loads the value being driven. For example, when A is driving real-time B data, a capture of A loads the B input into the A→B register.
- R10: The controls and data of one lane never affect the outputs or registers of the other lane.
- R11: A synchronous active-low `rst_n` clears both registers and the hold value in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_ab | input | 2 | Per-lane capture strobe for the A→B register (rising edge) |
| cap_ba | input | 2 | Per-lane capture strobe for the B→A register (rising edge) |
| sel_ab | input | 2 | Per-lane B output source: 0 live A, 1 stored |
| sel_ba | input | 2 | Per-lane A output source: 0 live B, 1 stored |
| oe_ab | input | 2 | Per-lane B drive enable, active high |
| oe_ba_n | input | 2 | Per-lane A drive enable, active low |
| a_in | input | 16 | External value on bus A |
| a_out | output | 16 | Value driven onto bus A |
| a_oe | output | 2 | Per-lane A drive indication |
| b_in | input | 16 | External value on bus B |
| b_out | output | 16 | Value driven onto bus B |
| b_oe | output | 2 | Per-lane B drive indication |

## Verification
Capture and driving can happen in the same cycle, and both can act on the same lane. The register that is loaded must then take the value that the block is driving, not the external input. The bench provokes this in a directed phase: it strobes A capture while A is driving live B data, and then switches B to stored mode so the captured value appears at the ports. A long random phase also overlaps strobes with every mode. Each cycle, the outputs of both lanes are compared with a behavioural reference. The reference works out the driven value in its own order and updates its copies of the registers and the hold value after the comparison.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  typedef enum logic [2:0] {
    LM_ISOLATE,
    LM_TO_B_ONLY,
    LM_TO_A_ONLY,
    LM_SELF_HOLD,
    LM_CROSS_STORED,
    LM_MIXED
  } lane_mode_e;

  // A side drives its neighbour's live value only when enabled and not stored
  function automatic logic live_path(input logic drive, input logic sel_stored);
    return drive & ~sel_stored;
  endfunction

  function automatic lane_mode_e lane_mode(input logic drv_a, input logic drv_b,
                                           input logic sel_ab, input logic sel_ba);
    lane_mode_e m;
    if (!drv_a && !drv_b)                 m = LM_ISOLATE;
    else if (drv_b && !drv_a)             m = LM_TO_B_ONLY;
    else if (drv_a && !drv_b)             m = LM_TO_A_ONLY;
    else if (!sel_ab && !sel_ba)          m = LM_SELF_HOLD;
    else if (sel_ab && sel_ba)            m = LM_CROSS_STORED;
    else                                  m = LM_MIXED;
    return m;
  endfunction

endpackage

// File: rtl/bxr_edge.sv
module bxr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] pulse
);
  logic [N-1:0] strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe;
  end

  assign pulse = strobe & ~strobe_q;
endmodule

// File: rtl/bxr_capreg.sv
module bxr_capreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bxr_lane.sv
module bxr_lane
  import bxr_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] a_in,
  input  logic [LW-1:0] b_in,
  input  logic          drv_a,
  input  logic          drv_b,
  input  logic          sel_ab,
  input  logic          sel_ba,
  input  logic          load_ab,
  input  logic          load_ba,
  output logic [LW-1:0] a_bus,
  output logic [LW-1:0] b_bus,
  output logic [LW-1:0] stored_ab,
  output logic [LW-1:0] stored_ba,
  output logic          self_hold
);
  lane_mode_e    mode;
  logic          a_live, b_live;
  logic [LW-1:0] a_root, b_root, held;

  assign mode      = lane_mode(drv_a, drv_b, sel_ab, sel_ba);
  assign self_hold = (mode == LM_SELF_HOLD);
  assign a_live    = live_path(drv_a, sel_ba);
  assign b_live    = live_path(drv_b, sel_ab);

  // Value of each side ignoring any live feed from the neighbour
  assign a_root = (drv_a && sel_ba) ? stored_ba : a_in;
  assign b_root = (drv_b && sel_ab) ? stored_ab : b_in;

  always_comb begin
    if (self_hold) begin
      a_bus = held;
      b_bus = held;
    end else begin
      a_bus = a_live ? b_root : a_root;
      b_bus = b_live ? a_root : b_root;
    end
  end

  // Bus keeper: follows the A side, frozen while the lane holds itself
  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= a_bus;
  end

  bxr_capreg #(.W(LW)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .load(load_ab), .d(a_bus), .q(stored_ab)
  );

  bxr_capreg #(.W(LW)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .load(load_ba), .d(b_bus), .q(stored_ba)
  );
endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg #(
  parameter int WIDTH = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cap_ab,
  input  logic [LANES-1:0] cap_ba,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [LANES-1:0] oe_ab,
  input  logic [LANES-1:0] oe_ba_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [LANES-1:0] b_oe
);
  localparam int LW = WIDTH / LANES;

  logic [LANES-1:0] load_ab, load_ba, drv_a, drv_b;
  logic [WIDTH-1:0] a_bus_w, b_bus_w, stored_ab_w, stored_ba_w;
  logic [LANES-1:0] self_hold_w;

  assign drv_b = oe_ab;
  assign drv_a = ~oe_ba_n;
  assign a_oe  = drv_a;
  assign b_oe  = drv_b;

  bxr_edge #(.N(LANES)) u_edge_ab (.clk(clk), .rst_n(rst_n), .strobe(cap_ab), .pulse(load_ab));
  bxr_edge #(.N(LANES)) u_edge_ba (.clk(clk), .rst_n(rst_n), .strobe(cap_ba), .pulse(load_ba));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LW;

    bxr_lane #(.LW(LW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_in      (a_in[LO +: LW]),
      .b_in      (b_in[LO +: LW]),
      .drv_a     (drv_a[l]),
      .drv_b     (drv_b[l]),
      .sel_ab    (sel_ab[l]),
      .sel_ba    (sel_ba[l]),
      .load_ab   (load_ab[l]),
      .load_ba   (load_ba[l]),
      .a_bus     (a_bus_w[LO +: LW]),
      .b_bus     (b_bus_w[LO +: LW]),
      .stored_ab (stored_ab_w[LO +: LW]),
      .stored_ba (stored_ba_w[LO +: LW]),
      .self_hold (self_hold_w[l])
    );

    assign a_out[LO +: LW] = drv_a[l] ? a_bus_w[LO +: LW] : '0;
    assign b_out[LO +: LW] = drv_b[l] ? b_bus_w[LO +: LW] : '0;
  end
endmodule

// File: rtl/bus_xfer_reg_chk.sv
module bus_xfer_reg_chk #(
  parameter int WIDTH = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] cap_ab,
  input logic [LANES-1:0] cap_ba,
  input logic [LANES-1:0] sel_ab,
  input logic [LANES-1:0] sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic [LANES-1:0] a_oe,
  input logic [LANES-1:0] b_oe,
  input logic [WIDTH-1:0] a_bus_w,
  input logic [WIDTH-1:0] b_bus_w,
  input logic [WIDTH-1:0] stored_ab_w,
  input logic [WIDTH-1:0] stored_ba_w,
  input logic [LANES-1:0] self_hold_w
);
  localparam int LW = WIDTH / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    localparam int LO = l * LW;

    AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_ab[l]) |=> stored_ab_w[LO +: LW] == $past(a_bus_w[LO +: LW])); // R1
    AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_ba[l]) |=> stored_ba_w[LO +: LW] == $past(b_bus_w[LO +: LW])); // R2
    AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[l] && !sel_ab[l] && !self_hold_w[l]) |-> b_out[LO +: LW] == a_bus_w[LO +: LW]); // R4
    AST_ISOLATED_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_oe[l] && !b_oe[l]) |-> (a_bus_w[LO +: LW] == a_in[LO +: LW] &&
                                 b_bus_w[LO +: LW] == b_in[LO +: LW])); // R6
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      self_hold_w[l] |=> (!self_hold_w[l] || $stable(a_bus_w[LO +: LW]))); // R7
    AST_CROSS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[l] && b_oe[l] && sel_ab[l] && sel_ba[l]) |->
        (a_out[LO +: LW] == stored_ba_w[LO +: LW] && b_out[LO +: LW] == stored_ab_w[LO +: LW])); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (stored_ab_w[LO +: LW] == '0 && stored_ba_w[LO +: LW] == '0)); // R11
  end
endmodule

bind bus_xfer_reg bus_xfer_reg_chk #(.WIDTH(WIDTH), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .a_bus_w(a_bus_w), .b_bus_w(b_bus_w), .stored_ab_w(stored_ab_w),
  .stored_ba_w(stored_ba_w), .self_hold_w(self_hold_w)
);

// File: tb/test_bus_xfer_reg.sv
`timescale 1ns/1ps
module test_bus_xfer_reg;
  localparam int WIDTH = 16;
  localparam int LANES = 2;
  localparam int LW    = WIDTH / LANES;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] cap_ab, cap_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
  logic [WIDTH-1:0] a_in, b_in, a_out, b_out;
  logic [LANES-1:0] a_oe, b_oe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string phase = "R11";

  // Reference state, one entry per lane
  logic [LW-1:0] m_ab [LANES];
  logic [LW-1:0] m_ba [LANES];
  logic [LW-1:0] m_hold [LANES];
  logic          m_pab [LANES];
  logic          m_pba [LANES];

  always #10 clk = ~clk;

  bus_xfer_reg #(.WIDTH(WIDTH), .LANES(LANES)) i_bus_xfer_reg (
    .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // Resolve the two bus values of a lane from the reference state
  task automatic model_eval(input int l, output logic [LW-1:0] av, output logic [LW-1:0] bv);
    logic da, db;
    da = !oe_ba_n[l];
    db = oe_ab[l];
    if (da && db && !sel_ab[l] && !sel_ba[l]) begin
      av = m_hold[l];
      bv = m_hold[l];
    end else begin
      if (!db)            bv = b_in[l*LW +: LW];
      else if (sel_ab[l]) bv = m_ab[l];
      else                bv = '0;
      if (!da)            av = a_in[l*LW +: LW];
      else if (sel_ba[l]) av = m_ba[l];
      else                av = bv;
      if (db && !sel_ab[l]) bv = av;
    end
  endtask

  function automatic string mode_tag(input int l);
    if (oe_ab[l] == 1'b0 && oe_ba_n[l] == 1'b1)                 return "R6";
    if (oe_ab[l] && !oe_ba_n[l] && !sel_ab[l] && !sel_ba[l])    return "R7";
    if (oe_ab[l] && !oe_ba_n[l] && sel_ab[l] && sel_ba[l])      return "R8";
    if (oe_ab[l] && sel_ab[l])                                  return "R5";
    if (oe_ab[l])                                               return "R4";
    return "R3";
  endfunction

  task automatic check_side(input string tag, input int l, input string side,
                            input logic got_oe, input logic [LW-1:0] got,
                            input logic exp_oe, input logic [LW-1:0] exp);
    compared++;
    if (got_oe !== exp_oe || got !== exp) begin
      mismatched++;
      $display("FAIL %s/%s lane %0d side %s: actual oe=%b data=%h expected oe=%b data=%h (t=%0t)",
               tag, phase, l, side, got_oe, got, exp_oe, exp, $time);
    end
  endtask

  // Inputs are already set after a falling edge; compare mid-phase, then
  // advance the reference to what the next rising edge does.
  task automatic step();
    logic [LW-1:0] av, bv;
    #5;
    for (int l = 0; l < LANES; l++) begin
      model_eval(l, av, bv);
      if (rst_n) begin
        check_side(mode_tag(l), l, "A", a_oe[l], a_out[l*LW +: LW],
                   !oe_ba_n[l], !oe_ba_n[l] ? av : '0);   // R3 polarity and idle zero
        check_side(mode_tag(l), l, "B", b_oe[l], b_out[l*LW +: LW],
                   oe_ab[l], oe_ab[l] ? bv : '0);
      end
      if (!rst_n) begin
        m_ab[l] = '0; m_ba[l] = '0; m_hold[l] = '0; m_pab[l] = 1'b0; m_pba[l] = 1'b0;
      end else begin
        if (cap_ab[l] && !m_pab[l]) m_ab[l] = av;   // R1
        if (cap_ba[l] && !m_pba[l]) m_ba[l] = bv;   // R2
        m_hold[l] = av;
        m_pab[l]  = cap_ab[l];
        m_pba[l]  = cap_ba[l];
      end
    end
    @(negedge clk);
  endtask

  // ctrl bits: [3] oe_ab, [2] oe_ba_n, [1] sel_ab, [0] sel_ba
  task automatic set_ctrl(input int l, input logic [3:0] c);
    oe_ab[l] = c[3]; oe_ba_n[l] = c[2]; sel_ab[l] = c[1]; sel_ba[l] = c[0];
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual run still going, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cap_ab = '0; cap_ba = '0; a_in = '0; b_in = '0;
    set_ctrl(0, 4'b0100); set_ctrl(1, 4'b0100);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      cap_ab = '1; cap_ba = '1; a_in = 16'hFFFF; b_in = 16'hFFFF;
      step();
    end
    rst_n = 1'b1;
    cap_ab = '0; cap_ba = '0;

    // R11: stored outputs after reset read zero
    phase = "R11";
    set_ctrl(0, 4'b1011); set_ctrl(1, 4'b1011);
    step();
    step();

    // R3 R4 R5: every control combination in each lane
    phase = "R3";
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 6; k++) begin
        set_ctrl(0, m[3:0]);
        set_ctrl(1, m[3:0] ^ 4'hA);
        a_in = 16'($urandom); b_in = 16'($urandom);
        cap_ab = 2'($urandom); cap_ba = 2'($urandom);
        step();
      end
    end

    // R7: enter self-hold from isolation, inputs churn, value must stay
    phase = "R7";
    set_ctrl(0, 4'b0100);
    a_in[7:0] = 8'h5A; b_in[7:0] = 8'hC3;
    step();
    set_ctrl(0, 4'b1000);
    for (int k = 0; k < 6; k++) begin
      a_in = 16'($urandom); b_in = 16'($urandom);
      cap_ab[0] = k[0]; cap_ba[0] = ~k[0];
      step();
    end

    // R9: capture A while A drives live B data, then show it stored on B
    phase = "R9";
    cap_ab = '0; cap_ba = '0;
    set_ctrl(0, 4'b0000);
    b_in[7:0] = 8'h3C; a_in[7:0] = 8'h81;
    step();
    cap_ab[0] = 1'b1;
    step();
    cap_ab[0] = 1'b0;
    set_ctrl(0, 4'b1110);
    b_in[7:0] = 8'h00;
    step();

    // R6: isolated lane still captures
    phase = "R6";
    set_ctrl(0, 4'b0100);
    a_in[7:0] = 8'h77; b_in[7:0] = 8'h11;
    cap_ab[0] = 1'b1; cap_ba[0] = 1'b1;
    step();
    cap_ab[0] = 1'b0; cap_ba[0] = 1'b0;
    set_ctrl(0, 4'b1011);
    step();

    // R10: lane 1 held in cross-stored mode while lane 0 churns
    phase = "R10";
    set_ctrl(1, 4'b1011);
    for (int k = 0; k < 300; k++) begin
      set_ctrl(0, 4'($urandom));
      a_in[7:0] = 8'($urandom); b_in[7:0] = 8'($urandom);
      cap_ab[0] = 1'($urandom); cap_ba[0] = 1'($urandom);
      step();
    end

    // R1 R2 R8: long random overlap of strobes and modes
    phase = "R1";
    for (int k = 0; k < 3000; k++) begin
      set_ctrl(0, 4'($urandom)); set_ctrl(1, 4'($urandom));
      a_in = 16'($urandom); b_in = 16'($urandom);
      cap_ab = 2'($urandom); cap_ba = 2'($urandom);
      step();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule